// File: doc/BRIEF.md
# Load-Linked Access Unit

This unit serves the first half of an atomic read-modify-write pair inside a processor pipeline. The pipeline hands it a load-linked request: a virtual address, a size selector (32-bit word or 64-bit doubleword) and a flag saying whether the core is in debug mode. A translated physical address for that request arrives on a separate input in the same cycle. The unit checks alignment first. A misaligned request gets no memory read. Instead the unit raises a one-cycle address-error-on-load exception and, outside debug mode, records the faulting virtual address.

An aligned request starts a read on a valid/ready memory port. When the response beat is accepted, the unit returns the value to the pipeline. A word result is sign-extended to 64 bits. In the same cycle it records the link state: the physical address, the virtual address and the returned value. It also sets a link-valid flag for the later store-conditional logic. A synchronous clear input drops that flag.

Top module: `ll_unit`

## Requirements
- R1: A word request is misaligned when vaddr[1:0] is non-zero, and a doubleword request is misaligned when vaddr[2:0] is non-zero. A misaligned request makes `exc_valid` high for exactly the one cycle after acceptance, with `exc_cause` = 5'd4, and no memory read is issued.
- R2: On a misaligned request with `req_debug` low, `badvaddr` takes the request's virtual address one cycle after acceptance. With `req_debug` high, `badvaddr` keeps its previous value.
- R3: An aligned request makes `mem_rd_valid` high from the cycle after acceptance until `mem_rd_ready` is seen. During that time `mem_rd_addr` holds the `xlat_paddr` sampled at acceptance and `mem_rd_dword` holds the request size. After that, `mem_rsp_ready` stays high until a response beat arrives.
- R4: `req_ready` is high only when no access is in progress. A request presented while a read is outstanding is not accepted and has no effect.
- R5: `res_valid` is high for exactly the one cycle after a response beat is accepted. For a word access `res_data` is `mem_rsp_data[31:0]` with bit 31 copied into bits 63:32. For a doubleword access it is `mem_rsp_data` unchanged.
- R6: `link_paddr`, `link_vaddr` and `link_data` change only when a response beat is accepted. They then take the request's physical address, its virtual address and the extended result.
- R7: `link_valid` is set by an accepted response beat and cleared by `link_clear`. When both happen in the same cycle, the clear wins.
- R8: After reset every output register is zero: link state, `badvaddr`, `link_valid`, `exc_valid`, `res_valid`.
- R9: A misaligned request leaves `link_valid`, `link_paddr`, `link_vaddr` and `link_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load-linked request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_vaddr | input | VA_W | Request virtual address |
| req_dword | input | 1 | 1 = doubleword, 0 = word |
| req_debug | input | 1 | Core is in debug mode |
| xlat_paddr | input | PA_W | Translated address of `req_vaddr` |
| mem_rd_valid | output | 1 | Read command valid |
| mem_rd_ready | input | 1 | Memory takes the read command |
| mem_rd_addr | output | PA_W | Read physical address |
| mem_rd_dword | output | 1 | Read size, 1 = doubleword |
| mem_rsp_valid | input | 1 | Read data beat present |
| mem_rsp_ready | output | 1 | Unit waits for read data |
| mem_rsp_data | input | XLEN | Read data |
| res_valid | output | 1 | Result pulse to pipeline |
| res_data | output | XLEN | Extended result |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause code (4 = address error on load) |
| link_clear | input | 1 | Drop the link flag |
| link_valid | output | 1 | Link flag for store-conditional |
| link_paddr | output | PA_W | Linked physical address |
| link_vaddr | output | VA_W | Linked virtual address |
| link_data | output | XLEN | Linked value |
| badvaddr | output | VA_W | Last faulting virtual address |

## Verification
The bench targets addresses that are aligned for a word but not for a doubleword. A size-blind check would either fault on a good word access or let a misaligned doubleword through. It returns words with bit 31 set and clear, because zero-extension or a wrong sign bit would corrupt the upper half. It repeats a misaligned access in debug mode, where a unit that ignores the flag overwrites `badvaddr`. It changes `xlat_paddr` after acceptance, which exposes a unit that does not latch the translation. It also holds a request high during an outstanding read, and it pulses `link_clear` in the very cycle of the response beat, where a set-wins priority would leave the link flag standing.

// File: rtl/ll_pkg.sv
// Shared types and codes for the load-linked access unit.
package ll_pkg;
    // Cause code reported for an address error on a load.
    localparam logic [4:0] CAUSE_ADDR_LOAD = 5'd4;

    // Control states: idle, read command pending, read data pending.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } ll_state_e;
endpackage

// File: rtl/ll_align_check.sv
// Alignment check for word and doubleword load-linked requests.
// Assumes the caller passes only the low address bits that matter for
// the widest access; the word check uses the lower part of them.
module ll_align_check #(
    parameter int DW_LSB = 3,
    parameter int W_LSB  = 2
) (
    input  logic [DW_LSB-1:0] addr_lsb,
    input  logic              dword,
    output logic              misaligned
);
    // Pick the mask width from the access size.
    always_comb begin
        if (dword) misaligned = |addr_lsb;
        else       misaligned = |addr_lsb[W_LSB-1:0];
    end
endmodule

// File: rtl/ll_ctrl.sv
// Sequencer for the load-linked unit: accepts a request when idle, fans
// out to an exception pulse or a two-phase memory read, and produces the
// one-cycle result pulse. Assumes the memory never returns data before
// the read command has been taken.
module ll_ctrl
    import ll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       misaligned,
    input  logic       mem_rd_ready,
    input  logic       mem_rsp_valid,
    output logic       req_ready,
    output logic       mem_rd_valid,
    output logic       mem_rsp_ready,
    output logic       take_good,
    output logic       take_bad,
    output logic       beat,
    output logic       exc_valid,
    output logic [4:0] exc_cause,
    output logic       res_valid
);
    ll_state_e state_q, state_d;

    // Handshake decode from the current state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_rd_valid  = (state_q == ST_ISSUE);
        mem_rsp_ready = (state_q == ST_WAIT);
        take_good     = req_valid && req_ready && !misaligned;
        take_bad      = req_valid && req_ready && misaligned;
        beat          = mem_rsp_ready && mem_rsp_valid;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (take_good) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_rd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and the registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            exc_valid <= 1'b0;
            exc_cause <= '0;
            res_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            exc_valid <= take_bad;
            exc_cause <= take_bad ? CAUSE_ADDR_LOAD : 5'd0;
            res_valid <= beat;
        end
    end
endmodule

// File: rtl/ll_link_regs.sv
// Storage for the load-linked unit: the request captured at acceptance,
// the link state written on the response beat, the link flag and the
// faulting-address register. Assumes XLEN is wider than WORD_W.
module ll_link_regs #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_good,
    input  logic            take_bad,
    input  logic            beat,
    input  logic            link_clear,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_dword,
    input  logic            req_debug,
    input  logic [PA_W-1:0] xlat_paddr,
    input  logic [XLEN-1:0] rsp_data,
    output logic [PA_W-1:0] pend_paddr,
    output logic            pend_dword,
    output logic            link_valid,
    output logic [PA_W-1:0] link_paddr,
    output logic [VA_W-1:0] link_vaddr,
    output logic [XLEN-1:0] link_data,
    output logic [VA_W-1:0] badvaddr
);
    localparam int EXT_W = XLEN - WORD_W;

    logic [VA_W-1:0] pend_vaddr;
    logic [XLEN-1:0] ext_data;

    // Word results copy the word's top bit into the upper part.
    always_comb begin
        if (pend_dword) ext_data = rsp_data;
        else            ext_data = {{EXT_W{rsp_data[WORD_W-1]}}, rsp_data[WORD_W-1:0]};
    end

    // Request capture, fault address, link state and link flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_paddr <= '0;
            pend_vaddr <= '0;
            pend_dword <= 1'b0;
            badvaddr   <= '0;
            link_paddr <= '0;
            link_vaddr <= '0;
            link_data  <= '0;
            link_valid <= 1'b0;
        end else begin
            if (take_good) begin
                pend_paddr <= xlat_paddr;
                pend_vaddr <= req_vaddr;
                pend_dword <= req_dword;
            end
            if (take_bad && !req_debug) begin
                badvaddr <= req_vaddr;
            end
            if (beat) begin
                link_paddr <= pend_paddr;
                link_vaddr <= pend_vaddr;
                link_data  <= ext_data;
            end
            if (link_clear)  link_valid <= 1'b0;
            else if (beat)   link_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/ll_unit.sv
// Load-linked access unit top. Joins the alignment check, the sequencer
// and the link storage. Assumes xlat_paddr belongs to req_vaddr in the
// cycle the request is accepted.
module ll_unit #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_dword,
    input  logic            req_debug,
    input  logic [PA_W-1:0] xlat_paddr,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [PA_W-1:0] mem_rd_addr,
    output logic            mem_rd_dword,
    input  logic            mem_rsp_valid,
    output logic            mem_rsp_ready,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            res_valid,
    output logic [XLEN-1:0] res_data,
    output logic            exc_valid,
    output logic [4:0]      exc_cause,
    input  logic            link_clear,
    output logic            link_valid,
    output logic [PA_W-1:0] link_paddr,
    output logic [VA_W-1:0] link_vaddr,
    output logic [XLEN-1:0] link_data,
    output logic [VA_W-1:0] badvaddr
);
    localparam int DW_LSB = $clog2(XLEN / 8);
    localparam int W_LSB  = $clog2(WORD_W / 8);

    logic misaligned;
    logic take_good;
    logic take_bad;
    logic beat;

    ll_align_check #(
        .DW_LSB(DW_LSB),
        .W_LSB (W_LSB)
    ) i_align (
        .addr_lsb  (req_vaddr[DW_LSB-1:0]),
        .dword     (req_dword),
        .misaligned(misaligned)
    );

    ll_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .misaligned   (misaligned),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .req_ready    (req_ready),
        .mem_rd_valid (mem_rd_valid),
        .mem_rsp_ready(mem_rsp_ready),
        .take_good    (take_good),
        .take_bad     (take_bad),
        .beat         (beat),
        .exc_valid    (exc_valid),
        .exc_cause    (exc_cause),
        .res_valid    (res_valid)
    );

    ll_link_regs #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .XLEN  (XLEN),
        .WORD_W(WORD_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_good (take_good),
        .take_bad  (take_bad),
        .beat      (beat),
        .link_clear(link_clear),
        .req_vaddr (req_vaddr),
        .req_dword (req_dword),
        .req_debug (req_debug),
        .xlat_paddr(xlat_paddr),
        .rsp_data  (mem_rsp_data),
        .pend_paddr(mem_rd_addr),
        .pend_dword(mem_rd_dword),
        .link_valid(link_valid),
        .link_paddr(link_paddr),
        .link_vaddr(link_vaddr),
        .link_data (link_data),
        .badvaddr  (badvaddr)
    );

    // The pipeline result is the value just linked.
    assign res_data = link_data;
endmodule

// File: rtl/ll_unit_chk.sv
// Protocol and timing properties of the load-linked unit, bound to it.
module ll_unit_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 32,
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_debug,
    input logic            mem_rd_valid,
    input logic            mem_rd_ready,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rsp_valid,
    input logic            mem_rsp_ready,
    input logic            res_valid,
    input logic            exc_valid,
    input logic [4:0]      exc_cause,
    input logic            link_clear,
    input logic            link_valid,
    input logic [PA_W-1:0] link_paddr,
    input logic [VA_W-1:0] link_vaddr,
    input logic [XLEN-1:0] link_data,
    input logic [VA_W-1:0] badvaddr
);
    AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !exc_valid); // R1
    AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause == 5'd4)); // R1
    AST_EXC_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !mem_rd_valid); // R1
    AST_DEBUG_KEEPS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_debug) |=> $stable(badvaddr)); // R2
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid || mem_rsp_ready) |-> !req_ready); // R4
    AST_RES_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R5
    AST_RES_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(mem_rsp_valid && mem_rsp_ready)); // R5
    AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rsp_valid && mem_rsp_ready) |=>
            ($stable(link_paddr) && $stable(link_vaddr) && $stable(link_data))); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        link_clear |=> !link_valid); // R7
endmodule

bind ll_unit ll_unit_chk #(
    .VA_W(VA_W),
    .PA_W(PA_W),
    .XLEN(XLEN)
) i_ll_unit_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_debug    (req_debug),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .res_valid    (res_valid),
    .exc_valid    (exc_valid),
    .exc_cause    (exc_cause),
    .link_clear   (link_clear),
    .link_valid   (link_valid),
    .link_paddr   (link_paddr),
    .link_vaddr   (link_vaddr),
    .link_data    (link_data),
    .badvaddr     (badvaddr)
);

// File: tb/test_ll_unit.sv
module test_ll_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_dword = 1'b0;
    logic        req_debug = 1'b0;
    logic [31:0] xlat_paddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_dword;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic        exc_valid;
    logic [4:0]  exc_cause;
    logic        link_clear = 1'b0;
    logic        link_valid;
    logic [31:0] link_paddr;
    logic [31:0] link_vaddr;
    logic [63:0] link_data;
    logic [31:0] badvaddr;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // Reference model state
    bit          exp_exc = 0;
    bit          exp_res = 0;
    bit          exp_lvalid = 0;
    logic [31:0] exp_lpa = '0;
    logic [31:0] exp_lva = '0;
    logic [63:0] exp_ldat = '0;
    logic [31:0] exp_bad = '0;

    always #5 clk = ~clk;

    ll_unit i_ll_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_dword(req_dword), .req_debug(req_debug), .xlat_paddr(xlat_paddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rd_dword(mem_rd_dword),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_data(res_data),
        .exc_valid(exc_valid), .exc_cause(exc_cause),
        .link_clear(link_clear), .link_valid(link_valid),
        .link_paddr(link_paddr), .link_vaddr(link_vaddr),
        .link_data(link_data), .badvaddr(badvaddr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    function automatic logic [63:0] extend(input logic [63:0] d, input bit dw);
        logic [63:0] r;
        if (dw) r = d;
        else if (d[31]) r = {32'hFFFF_FFFF, d[31:0]};
        else r = {32'h0, d[31:0]};
        return r;
    endfunction

    // Compare every output against the model 3 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (mon_on) begin
                chk(exc_valid === exp_exc, "R1 exc_valid", 64'(exc_valid), 64'(exp_exc));
                if (exp_exc) chk(exc_cause === 5'd4, "R1 exc_cause", 64'(exc_cause), 64'd4);
                chk(res_valid === exp_res, "R5 res_valid", 64'(res_valid), 64'(exp_res));
                if (exp_res) chk(res_data === exp_ldat, "R5 res_data", res_data, exp_ldat);
                chk(link_valid === exp_lvalid, "R7 link_valid", 64'(link_valid), 64'(exp_lvalid));
                chk(link_paddr === exp_lpa, "R6/R9 link_paddr", 64'(link_paddr), 64'(exp_lpa));
                chk(link_vaddr === exp_lva, "R6/R9 link_vaddr", 64'(link_vaddr), 64'(exp_lva));
                chk(link_data === exp_ldat, "R6/R9 link_data", link_data, exp_ldat);
                chk(badvaddr === exp_bad, "R2 badvaddr", 64'(badvaddr), 64'(exp_bad));
            end
        end
    end

    // One load-linked access with a bench-side memory.
    task automatic do_ll(input logic [31:0] va, input bit dw, input bit dbg,
                         input logic [31:0] pa, input logic [63:0] d,
                         input int rdly, input int rsdly, input bit clr_same, input bit poke);
        bit mis;
        mis = dw ? (va[2:0] != 3'b0) : (va[1:0] != 2'b0);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_dword = dw; req_debug = dbg; xlat_paddr = pa;
        chk(req_ready === 1'b1, "R4 ready when idle", 64'(req_ready), 64'd1);
        @(posedge clk);
        if (mis) begin
            exp_exc = 1;
            if (!dbg) exp_bad = va;
        end
        @(negedge clk);
        req_valid = 1'b0; xlat_paddr = ~pa;
        if (mis) begin
            chk(mem_rd_valid === 1'b0, "R1 no read on fault", 64'(mem_rd_valid), 64'd0);
            @(posedge clk);
            exp_exc = 0;
            return;
        end
        if (poke) begin
            req_valid = 1'b1; req_vaddr = 32'h0000_0003; req_dword = 1'b0; req_debug = 1'b0;
        end
        for (int i = 0; i < rdly; i++) begin
            chk(mem_rd_valid === 1'b1, "R3 read held", 64'(mem_rd_valid), 64'd1);
            chk(req_ready === 1'b0, "R4 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk(mem_rd_valid === 1'b1, "R3 read valid", 64'(mem_rd_valid), 64'd1);
        chk(mem_rd_addr === pa, "R3 read addr", 64'(mem_rd_addr), 64'(pa));
        chk(mem_rd_dword === dw, "R3 read size", 64'(mem_rd_dword), 64'(dw));
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        for (int i = 0; i < rsdly; i++) begin
            chk(mem_rsp_ready === 1'b1, "R3 rsp ready", 64'(mem_rsp_ready), 64'd1);
            chk(mem_rd_valid === 1'b0, "R3 read done", 64'(mem_rd_valid), 64'd0);
            chk(req_ready === 1'b0, "R4 busy", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        chk(mem_rsp_ready === 1'b1, "R3 rsp ready", 64'(mem_rsp_ready), 64'd1);
        mem_rsp_valid = 1'b1; mem_rsp_data = d;
        if (clr_same) link_clear = 1'b1;
        @(posedge clk);
        exp_res = 1; exp_lpa = pa; exp_lva = va; exp_ldat = extend(d, dw);
        exp_lvalid = !clr_same;
        @(negedge clk);
        mem_rsp_valid = 1'b0; link_clear = 1'b0; req_valid = 1'b0;
        @(posedge clk);
        exp_res = 0;
    endtask

    task automatic clear_link();
        @(negedge clk);
        link_clear = 1'b1;
        @(posedge clk);
        exp_lvalid = 0;
        @(negedge clk);
        link_clear = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        chk(link_valid === 1'b0, "R8 link_valid", 64'(link_valid), 64'd0);
        chk(link_data === 64'd0, "R8 link_data", link_data, 64'd0);
        chk(badvaddr === 32'd0, "R8 badvaddr", 64'(badvaddr), 64'd0);
        chk(exc_valid === 1'b0, "R8 exc_valid", 64'(exc_valid), 64'd0);
        chk(res_valid === 1'b0, "R8 res_valid", 64'(res_valid), 64'd0);
        chk(req_ready === 1'b1, "R8 idle", 64'(req_ready), 64'd1);
        mon_on = 1'b1;

        // R3 R5 R6: word, positive, no delays
        do_ll(32'h1000_0010, 0, 0, 32'h0020_0010, 64'hDEAD_BEEF_1234_5678, 0, 0, 0, 0);
        // R5: word with bit 31 set, delays, busy poke (R4)
        do_ll(32'h1000_0024, 0, 0, 32'h0020_0024, 64'h0000_0000_8765_4321, 2, 3, 0, 1);
        // R5: doubleword passes through
        do_ll(32'h2000_0008, 1, 0, 32'h0030_0008, 64'hF123_4567_89AB_CDEF, 1, 0, 0, 0);
        // R1 R2 R9: word misaligned
        do_ll(32'h3000_0001, 0, 0, 32'h0040_0000, 64'h0, 0, 0, 0, 0);
        // R1 R2 R9: doubleword aligned for word only
        do_ll(32'h3000_0104, 1, 0, 32'h0040_0100, 64'h0, 0, 0, 0, 0);
        // R1: word at same kind of address is fine
        do_ll(32'h3000_0204, 0, 0, 32'h0040_0204, 64'h0000_0000_7FFF_FFFF, 0, 1, 0, 0);
        // R2: misaligned in debug mode keeps badvaddr
        do_ll(32'h3000_0302, 0, 1, 32'h0040_0300, 64'h0, 0, 0, 0, 0);
        do_ll(32'h3000_0406, 1, 1, 32'h0040_0400, 64'h0, 0, 0, 0, 0);
        // R7: clear alone
        clear_link();
        // R7: set again, then clear in the beat cycle
        do_ll(32'h4000_0000, 1, 0, 32'h0050_0000, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0);
        do_ll(32'h4000_0018, 0, 0, 32'h0050_0018, 64'h1111_2222_FFFF_0000, 1, 1, 1, 0);
        // R1: misaligned after all that, link state stays (R9)
        do_ll(32'h4000_0023, 1, 0, 32'h0050_0020, 64'h0, 0, 0, 0, 0);

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule